// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept, using only its destination address. The six destination bytes arrive one per clock, the first one marked by a start strobe. One cycle after the sixth byte, the block raises a one-cycle decision strobe together with an accept flag.

Several configuration inputs shape the decision, in this priority order:

- Promiscuous mode accepts every frame.
- The all-ones broadcast address is accepted or rejected according to a reject-broadcast control bit.
- A group (multicast) address is looked up in a 64-entry hash bitmap. The bitmap is indexed by the top bits of the CRC-32 of the destination bytes.
- Any other address must equal the 48-bit station address exactly.

The block fits in a receive path just after the preamble and start-of-frame delimiter have been stripped. Its configuration inputs come straight from control registers held elsewhere.

Top module: `dstfilt_top`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `decValid` and `decAccept` are both 0.
- R2: `decValid` is high for exactly one cycle, namely the cycle after the clock edge that samples the sixth address byte. `decAccept` is never high while `decValid` is low.
- R3: The station address is placed as follows: byte 0 (first on the wire) in `stationHi[15:8]`, byte 1 in `stationHi[7:0]`, byte 2 in `stationLo[31:24]`, byte 3 in `stationLo[23:16]`, byte 4 in `stationLo[15:8]` and byte 5 in `stationLo[7:0]`. An individual address (byte 0 bit 0 clear) equal to it in all six bytes is accepted.
- R4: An individual address that differs from the station address in any single byte is rejected when promiscuous mode is off.
- R5: The address FF:FF:FF:FF:FF:FF is accepted when `bcastReject` is 0 and rejected when it is 1. The hash bitmap and the station address do not affect this.
- R6: With `promiscEn` = 1, every address is accepted, including a broadcast while `bcastReject` = 1.
- R7: A group address (byte 0 bit 0 set, not all ones) has its CRC computed as follows: polynomial 0x04C11DB7, register preset to all ones, each byte fed bit 0 first, no final inversion. Bits 31:26 of that CRC form an index. Index bit 5 selects `hashHi` (1) or `hashLo` (0), and index bits 4:0 select the bit inside it. The frame is accepted exactly when that bit is 1.
- R8: With both hash words all ones, every group address is accepted.
- R9: A byte presented with `dstValid` high but outside a frame (no start strobe since the last completed address) is ignored and produces no decision. A start strobe part-way through an address restarts the count at byte 0.
- R10: Cycles with `dstValid` low between address bytes stall the byte count without losing state. The decision still follows the sixth valid byte by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dstValid | input | 1 | `dstByte` carries an address byte this cycle |
| dstStart | input | 1 | With `dstValid`, marks byte 0 of the destination address |
| dstByte | input | 8 | Destination address byte, first byte on the wire first |
| stationLo | input | 32 | Station address bytes 2..5 |
| stationHi | input | 16 | Station address bytes 0..1 |
| hashLo | input | 2**(HASH_IDX_W-1) | Hash bitmap, indices with top index bit 0 |
| hashHi | input | 2**(HASH_IDX_W-1) | Hash bitmap, indices with top index bit 1 |
| promiscEn | input | 1 | Accept every frame |
| bcastReject | input | 1 | Reject the broadcast address |
| decValid | output | 1 | Decision strobe |
| decAccept | output | 1 | Frame accepted (meaningful with `decValid`) |

## Verification
The bench builds the block with its default hash index width of six bits, which gives two 32-bit hash words and the standard 64-entry bitmap. At this width, the bench's own CRC model selects one exact bitmap bit. Setting only that bit, and then every bit except it, shows that the lookup hits the right word and the right position. The same configuration also reaches the priority corners:

- promiscuous mode overriding a broadcast reject
- stray bytes outside a frame
- a restart part-way through an address
- idle gaps between bytes

// File: rtl/dstfilt_pkg.sv
package dstfilt_pkg;

  localparam int ADDR_BYTES = 6;
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  // Strobes from control to datapath for one address byte.
  typedef struct packed {
    logic take;                // a byte is consumed this cycle
    logic first;               // it is byte 0: preset running state
    logic last;                // it is the final byte: register verdict
    logic [CNT_W-1:0] idx;     // byte position within the address
  } strobe_t;

  // One byte through the CRC register, bit 0 of the byte first.
  function automatic logic [31:0] crcStep(input logic [31:0] cIn, input logic [7:0] b);
    logic [31:0] c;
    logic fb;
    c = cIn;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ b[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/dstfilt_ctrl.sv
module dstfilt_ctrl
  import dstfilt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    dstValid,
  input  logic    dstStart,
  output strobe_t stb,
  output logic    decValid
);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curIdx;

  always_comb begin
    stb    = '0;
    curIdx = dstStart ? '0 : cnt;
    if (dstValid && (dstStart || busy)) begin
      stb.take  = 1'b1;
      stb.first = dstStart;
      stb.idx   = curIdx;
      stb.last  = (curIdx == CNT_W'(ADDR_BYTES - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cnt      <= '0;
      decValid <= 1'b0;
    end else begin
      decValid <= stb.last;
      if (stb.take) begin
        if (stb.last) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          busy <= 1'b1;
          cnt  <= curIdx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dstfilt_datapath.sv
module dstfilt_datapath
  import dstfilt_pkg::*;
#(
  parameter int HASH_IDX_W = 6
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        stb,
  input  logic [7:0]                     dstByte,
  input  logic [31:0]                    stationLo,
  input  logic [15:0]                    stationHi,
  input  logic [(1<<(HASH_IDX_W-1))-1:0] hashLo,
  input  logic [(1<<(HASH_IDX_W-1))-1:0] hashHi,
  input  logic                           promiscEn,
  input  logic                           bcastReject,
  output logic                           decAccept
);

  localparam int HASH_HALF = 1 << (HASH_IDX_W - 1);
  localparam int HASH_BITS = 2 * HASH_HALF;

  logic [47:0]           station48;
  logic [7:0]            stationByte [ADDR_BYTES];
  logic [7:0]            stationSel;
  logic [HASH_BITS-1:0]  hashVec;
  logic [HASH_IDX_W-1:0] hashIdx;
  logic                  hashHit;

  logic [31:0] crcReg, crcNext;
  logic        matchReg, matchNext;
  logic        bcastReg, bcastNext;
  logic        mcastReg, mcastNext;
  logic        verdict;

  assign station48 = {stationHi, stationLo};
  assign hashVec   = {hashHi, hashLo};

  // Byte k of the station address, byte 0 in the top octet.
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_stationByte
    assign stationByte[k] = station48[8*(ADDR_BYTES-1-k) +: 8];
  end

  always_comb begin
    stationSel = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (stb.idx == CNT_W'(k)) stationSel = stationByte[k];
  end

  always_comb begin
    crcNext   = crcStep(stb.first ? 32'hFFFF_FFFF : crcReg, dstByte);
    matchNext = (stb.first ? 1'b1 : matchReg) && (dstByte == stationSel);
    bcastNext = (stb.first ? 1'b1 : bcastReg) && (dstByte == 8'hFF);
    mcastNext = stb.first ? dstByte[0] : mcastReg;
    hashIdx   = crcNext[31 -: HASH_IDX_W];
    hashHit   = hashVec[hashIdx];
    if (promiscEn)      verdict = 1'b1;
    else if (bcastNext) verdict = !bcastReject;
    else if (mcastNext) verdict = hashHit;
    else                verdict = matchNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg    <= '1;
      matchReg  <= 1'b0;
      bcastReg  <= 1'b0;
      mcastReg  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      if (stb.take) begin
        crcReg   <= crcNext;
        matchReg <= matchNext;
        bcastReg <= bcastNext;
        mcastReg <= mcastNext;
      end
      decAccept <= stb.last && verdict;
    end
  end

endmodule

// File: rtl/dstfilt_top.sv
module dstfilt_top
  import dstfilt_pkg::*;
#(
  parameter int HASH_IDX_W = 6
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           dstValid,
  input  logic                           dstStart,
  input  logic [7:0]                     dstByte,
  input  logic [31:0]                    stationLo,
  input  logic [15:0]                    stationHi,
  input  logic [(1<<(HASH_IDX_W-1))-1:0] hashLo,
  input  logic [(1<<(HASH_IDX_W-1))-1:0] hashHi,
  input  logic                           promiscEn,
  input  logic                           bcastReject,
  output logic                           decValid,
  output logic                           decAccept
);

  strobe_t stb;

  dstfilt_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .dstValid (dstValid),
    .dstStart (dstStart),
    .stb      (stb),
    .decValid (decValid)
  );

  dstfilt_datapath #(.HASH_IDX_W(HASH_IDX_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .dstByte     (dstByte),
    .stationLo   (stationLo),
    .stationHi   (stationHi),
    .hashLo      (hashLo),
    .hashHi      (hashHi),
    .promiscEn   (promiscEn),
    .bcastReject (bcastReject),
    .decAccept   (decAccept)
  );

endmodule

// File: rtl/dstfilt_chk.sv
module dstfilt_chk (
  input logic clk,
  input logic rstN,
  input logic dstValid,
  input logic promiscEn,
  input logic decValid,
  input logic decAccept
);

  // R2: accept only alongside the decision strobe
  p_accept_gated_r2: assert property (@(posedge clk) disable iff (!rstN)
    decAccept |-> decValid);

  // R2: the decision strobe lasts one cycle
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid);

  // R2 / R10: a decision follows a consumed byte directly
  p_follows_byte_r10: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(dstValid));

  // R9: an idle cycle never yields a decision in the next cycle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dstValid |=> !decValid);

  // R6: promiscuous mode at the last byte forces acceptance
  p_promisc_accepts_r6: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(promiscEn)) |-> decAccept);

endmodule

bind dstfilt_top dstfilt_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .dstValid  (dstValid),
  .promiscEn (promiscEn),
  .decValid  (decValid),
  .decAccept (decAccept)
);

// File: tb/dstfilt_top_tb_top.sv
module dstfilt_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dstValid = 1'b0;
  logic        dstStart = 1'b0;
  logic [7:0]  dstByte = 8'h00;
  logic [31:0] stationLo = '0;
  logic [15:0] stationHi = '0;
  logic [31:0] hashLo = '0;
  logic [31:0] hashHi = '0;
  logic        promiscEn = 1'b0;
  logic        bcastReject = 1'b0;
  logic        decValid;
  logic        decAccept;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  dstfilt_top #(.HASH_IDX_W(6)) dut_i (
    .clk(clk), .rstN(rstN), .dstValid(dstValid), .dstStart(dstStart),
    .dstByte(dstByte), .stationLo(stationLo), .stationHi(stationHi),
    .hashLo(hashLo), .hashHi(hashHi), .promiscEn(promiscEn),
    .bcastReject(bcastReject), .decValid(decValid), .decAccept(decAccept)
  );

  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference hash: MSB-shifting CRC, each byte fed from bit 0.
  function automatic logic [31:0] refCrc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int n = 0; n < 6; n++) begin
      logic [7:0] b = a[47-8*n -: 8];
      for (int i = 0; i < 8; i++) begin
        logic top = c[31];
        c = c << 1;
        if (top != b[i]) c = c ^ 32'h04C11DB7;
      end
    end
    return c;
  endfunction

  // Feed six bytes, gap idle cycles after each; return what appears
  // one cycle after the last byte and whether a decision came early.
  task automatic sendAddr(input logic [47:0] a, input int gap,
                          output logic gotValid, output logic gotAcc,
                          output logic early);
    early = 1'b0;
    for (int n = 0; n < 6; n++) begin
      dstValid = 1'b1;
      dstStart = (n == 0);
      dstByte  = a[47-8*n -: 8];
      @(negedge clk);
      if (n != 5) begin
        if (decValid) early = 1'b1;
        dstValid = 1'b0;
        dstStart = 1'b0;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (decValid) early = 1'b1;
        end
      end
    end
    dstValid = 1'b0;
    dstStart = 1'b0;
    gotValid = decValid;
    gotAcc   = decAccept;
  endtask

  task automatic expectDecision(input logic [47:0] a, input int gap,
                                input logic expAcc, input string req);
    logic v, acc, early;
    sendAddr(a, gap, v, acc, early);
    check(!early, req, "no early decision", early, 0);
    check(v == 1'b1, req, "decValid after sixth byte", v, 1);
    check(acc == expAcc, req, "decAccept", acc, expAcc);
    @(negedge clk);
  endtask

  task automatic testReset();
    check(decValid == 1'b0, "R1", "decValid in reset", decValid, 0);
    check(decAccept == 1'b0, "R1", "decAccept in reset", decAccept, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(decValid == 1'b0 && decAccept == 1'b0, "R1", "outputs after reset",
          {decValid, decAccept}, 0);
  endtask

  task automatic testUnicastMatch();
    logic v, acc, early;
    stationHi = 16'h0211;
    stationLo = 32'h2233_4455;
    sendAddr(STATION, 0, v, acc, early);
    check(v && acc, "R3", "station address accepted", {v, acc}, 3);
    @(negedge clk);
    check(decValid == 1'b0, "R2", "strobe is one cycle", decValid, 0);
    check(decAccept == 1'b0, "R2", "accept drops with strobe", decAccept, 0);
  endtask

  task automatic testUnicastMismatch();
    expectDecision(STATION ^ 48'h00_00_00_00_00_01, 0, 1'b0, "R4");
    expectDecision(STATION ^ 48'h04_00_00_00_00_00, 0, 1'b0, "R4");
    expectDecision(STATION ^ 48'h00_00_80_00_00_00, 0, 1'b0, "R4");
  endtask

  task automatic testBroadcast();
    hashLo = '0;
    hashHi = '0;
    bcastReject = 1'b0;
    expectDecision(BCAST, 0, 1'b1, "R5");
    bcastReject = 1'b1;
    hashLo = '1;
    hashHi = '1;
    expectDecision(BCAST, 0, 1'b0, "R5");
    hashLo = '0;
    hashHi = '0;
    bcastReject = 1'b0;
  endtask

  task automatic testPromisc();
    promiscEn = 1'b1;
    bcastReject = 1'b1;
    expectDecision(BCAST, 0, 1'b1, "R6");
    expectDecision(48'h00_AA_BB_CC_DD_EE, 0, 1'b1, "R6");
    expectDecision(48'h01_00_5E_12_34_56, 0, 1'b1, "R6");
    promiscEn = 1'b0;
    bcastReject = 1'b0;
  endtask

  task automatic testHash();
    logic [47:0] a [2];
    a[0] = 48'h01_00_5E_00_00_01;
    a[1] = 48'h33_33_00_00_00_FB;
    for (int n = 0; n < 2; n++) begin
      logic [5:0]  idx = refCrc(a[n])[31:26];
      logic [63:0] hv = 64'd0;
      hv[idx] = 1'b1;
      {hashHi, hashLo} = hv;
      expectDecision(a[n], 0, 1'b1, "R7");
      {hashHi, hashLo} = ~hv;
      expectDecision(a[n], 0, 1'b0, "R7");
    end
    hashHi = '0;
    hashLo = '0;
  endtask

  task automatic testAllOnes();
    hashHi = '1;
    hashLo = '1;
    expectDecision(48'h01_00_5E_7F_FF_FA, 0, 1'b1, "R8");
    expectDecision(48'h03_12_34_56_78_9A, 0, 1'b1, "R8");
    hashHi = '0;
    hashLo = '0;
  endtask

  task automatic testStrayAndRestart();
    logic seen = 1'b0;
    logic v, acc, early;
    // Bytes with no start strobe: no decision may appear.
    for (int n = 0; n < 8; n++) begin
      dstValid = 1'b1;
      dstStart = 1'b0;
      dstByte  = STATION[47-8*(n%6) -: 8];
      @(negedge clk);
      if (decValid) seen = 1'b1;
    end
    dstValid = 1'b0;
    @(negedge clk);
    if (decValid) seen = 1'b1;
    check(!seen, "R9", "stray bytes ignored", seen, 0);
    // Three bytes of a foreign address, then a fresh start.
    for (int n = 0; n < 3; n++) begin
      dstValid = 1'b1;
      dstStart = (n == 0);
      dstByte  = 8'hA0 + 8'(n);
      @(negedge clk);
    end
    sendAddr(STATION, 0, v, acc, early);
    check(!early, "R9", "restart yields no early decision", early, 0);
    check(v && acc, "R9", "restarted address accepted", {v, acc}, 3);
    @(negedge clk);
  endtask

  task automatic testGaps();
    expectDecision(STATION, 2, 1'b1, "R10");
    expectDecision(STATION ^ 48'h00_00_00_00_10_00, 3, 1'b0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testUnicastMatch();
    testUnicastMismatch();
    testBroadcast();
    testPromisc();
    testHash();
    testAllOnes();
    testStrayAndRestart();
    testGaps();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule